// File: doc/BRIEF.md
# Configurable 8-bit Synchronous Serial Port

This block moves one byte at a time over a three-wire clocked serial link: a shift clock, a data output and a data input. Software chooses the mode with a small control write. The mode sets the bit order (most or least significant bit first), full-duplex operation or receive-only operation, and where the shift clock comes from. The clock can be generated inside the block, which then acts as link master, or taken from the external clock pin, which makes the block a slave.

A write to the data register loads the outgoing byte, clears the completion flag and starts a transfer. The shift clock idles high. Each bit cell is a low half followed by a high half. Outgoing data moves on the falling edge of the clock, and incoming data is captured on the rising edge. After the eighth rising edge the received byte appears on the read port, the completion flag sets, and a one-cycle interrupt pulse fires. In receive-only mode the data output keeps its previous level for the whole transfer.

Top module: `bitser_port`

## Requirements
- R1: After reset, sck_o is 1, sck_oe is 1, sdo_o is 1, done and irq are 0, and rd_data is 0. The mode is full-duplex, LSB-first, internal clock.
- R2: In internal-clock mode (ctl_wdata bit 2 = 0), a data write produces exactly DATA_W low pulses on sck_o. Each low and each high half lasts DIV_HALF cycles. sck_o then stays high, and sck_o is high whenever no transfer is in progress.
- R3: With ctl_wdata bit 0 = 1, bits go out and are assembled most-significant first.
- R4: With ctl_wdata bit 0 = 0, bits go out and are assembled least-significant first.
- R5: sdi_i is captured at the clock edge on which the shift clock rises. sdo_o changes only at a falling edge of the shift clock, or at the start of an internal-clock transfer.
- R6: With ctl_wdata bit 1 = 1 (receive-only), sdo_o keeps its previous value for the whole transfer, and the received byte is still delivered.
- R7: With ctl_wdata bit 2 = 1, sck_oe is 0 and sck_o stays high. The block shifts on the edges of sck_i, taken through a SYNC_STAGES-deep synchronizer, and completes after DATA_W rising edges.
- R8: In internal mode, done rises (2*DATA_W-1)*DIV_HALF cycles after the clock edge that accepts the data write. irq is high for exactly that one cycle.
- R9: A data write accepted while idle clears done in the next cycle and starts the next transfer.
- R10: Data writes and control writes made while a transfer is in progress are ignored.
- R11: Edges on sck_i while no transfer is in progress change neither done, rd_data nor sdo_o, and they do not count toward the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Mode: bit0 MSB-first, bit1 receive-only, bit2 external clock |
| dat_we | input | 1 | Data write strobe; starts a transfer |
| dat_wdata | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last received byte |
| done | output | 1 | Transfer-complete flag |
| irq | output | 1 | One-cycle completion pulse |
| sck_i | input | 1 | Shift clock from the pin (slave mode) |
| sck_o | output | 1 | Generated shift clock (master mode) |
| sck_oe | output | 1 | Drive enable for sck_o |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions check a set of rules on every cycle. The clock must be high whenever the port is idle, and it must stay high in slave mode. The mode must stay frozen during a transfer, and a start is accepted only from idle. The output must hold in receive-only mode, done must rise only on a sampling edge, and the interrupt must last a single cycle. Other behaviour only the bench scenarios can show: the pulse count and duty of the generated clock, the serial bit order in both directions, the done latency, and capture on the rising edge. The same holds for slave transfers driven through the synchronizer and for the rejection of stray pin edges and of writes made mid-transfer.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

   // Mode word; packed so that ctl_wdata[0] is msb_first, [1] rx_only, [2] ext_clk
   typedef struct packed {
      logic ext_clk;
      logic rx_only;
      logic msb_first;
   } bitser_cfg_t;

   localparam int unsigned CFG_W = $bits(bitser_cfg_t);

   typedef enum logic [1:0] {
      CK_IDLE = 2'd0,
      CK_LOW  = 2'd1,
      CK_HIGH = 2'd2
   } ck_state_e;

endpackage

// File: rtl/bitser_clkgen.sv
module bitser_clkgen
   import bitser_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic sck_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int unsigned BIT_W = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST_PULSE = BIT_W'(DATA_W - 1);

   ck_state_e        state_q;
   logic [BIT_W-1:0] pulse_q;
   logic             half_end;

   // Half-period timer: a counter only when a half lasts more than one cycle
   generate
      if (DIV_HALF == 1) begin : g_no_div
         assign half_end = 1'b1;
      end else begin : g_div
         localparam int unsigned CNT_W = $clog2(DIV_HALF);
         localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DIV_HALF - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (state_q == CK_IDLE || cnt_q == CNT_END) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign half_end = (cnt_q == CNT_END);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CK_IDLE;
         sck_o   <= 1'b1;
         pulse_q <= '0;
      end else begin
         unique case (state_q)
            CK_IDLE: begin
               if (start_i) begin
                  state_q <= CK_LOW;
                  sck_o   <= 1'b0;
                  pulse_q <= '0;
               end
            end
            CK_LOW: begin
               if (half_end) begin
                  sck_o <= 1'b1;
                  if (pulse_q == LAST_PULSE) begin
                     state_q <= CK_IDLE;
                  end else begin
                     state_q <= CK_HIGH;
                     pulse_q <= pulse_q + 1'b1;
                  end
               end
            end
            CK_HIGH: begin
               if (half_end) begin
                  state_q <= CK_LOW;
                  sck_o   <= 1'b0;
               end
            end
            default: state_q <= CK_IDLE;
         endcase
      end
   end

   assign rise_o = (state_q == CK_LOW)  && half_end;
   assign fall_o = (state_q == CK_HIGH) && half_end;

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> state_q == CK_IDLE); // R10

endmodule

// File: rtl/bitser_sync.sv
module bitser_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise_o =  chain_q[STAGES-1] && !prev_q;
   assign fall_o = !chain_q[STAGES-1] &&  prev_q;

endmodule

// File: rtl/bitser_shifter.sv
module bitser_shifter
   import bitser_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  bitser_cfg_t       cfg_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              irq_o,
   output logic [DATA_W-1:0] rx_o
);

   localparam int unsigned BIT_W = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shift_nxt;
   logic [BIT_W-1:0]  bit_q;
   logic              out_bit;
   logic              first_bit;

   always_comb begin
      if (cfg_i.msb_first) begin
         shift_nxt = {shreg_q[DATA_W-2:0], sdi_i};
         out_bit   = shreg_q[DATA_W-1];
         first_bit = wr_data_i[DATA_W-1];
      end else begin
         shift_nxt = {sdi_i, shreg_q[DATA_W-1:1]};
         out_bit   = shreg_q[0];
         first_bit = wr_data_i[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         bit_q   <= '0;
         sdo_o   <= 1'b1;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         irq_o   <= 1'b0;
         rx_o    <= '0;
      end else begin
         irq_o <= 1'b0;
         if (start_i) begin
            shreg_q <= wr_data_i;
            bit_q   <= '0;
            busy_o  <= 1'b1;
            done_o  <= 1'b0;
            if (!cfg_i.rx_only && !cfg_i.ext_clk) begin
               sdo_o <= first_bit;
            end
         end else if (busy_o) begin
            if (fall_i && !cfg_i.rx_only) begin
               sdo_o <= out_bit;
            end
            if (rise_i) begin
               shreg_q <= shift_nxt;
               if (bit_q == LAST_BIT) begin
                  busy_o <= 1'b0;
                  done_o <= 1'b1;
                  irq_o  <= 1'b1;
                  rx_o   <= shift_nxt;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && busy_o)); // R9
   AST_RXONLY_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cfg_i.rx_only) |=> $stable(sdo_o)); // R6
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R8
   AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(rise_i)); // R8

endmodule

// File: rtl/bitser_port.sv
module bitser_port
   import bitser_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_HALF    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [2:0]        ctl_wdata,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   output logic              sdo_o,
   input  logic              sdi_i
);

   initial begin : elab_chk
      AST_PARAM_DATA_W: assert (DATA_W >= 2)
         else $error("DATA_W must be at least 2"); // R2
      AST_PARAM_DIV: assert (DIV_HALF >= 1)
         else $error("DIV_HALF must be at least 1"); // R2
      AST_PARAM_SYNC: assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2"); // R7
      AST_PARAM_CFG: assert (CFG_W == 3)
         else $error("mode word width mismatch"); // R1
   end

   bitser_cfg_t cfg_q;
   logic        busy;
   logic        start;
   logic        int_rise, int_fall;
   logic        ext_rise, ext_fall;
   logic        rise_ev, fall_ev;

   assign start = dat_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (ctl_we && !busy) begin
         cfg_q <= bitser_cfg_t'(ctl_wdata);
      end
   end

   bitser_clkgen #(
      .DATA_W   (DATA_W),
      .DIV_HALF (DIV_HALF)
   ) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start && !cfg_q.ext_clk),
      .sck_o   (sck_o),
      .rise_o  (int_rise),
      .fall_o  (int_fall)
   );

   bitser_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (sck_i),
      .rise_o (ext_rise),
      .fall_o (ext_fall)
   );

   assign rise_ev = cfg_q.ext_clk ? ext_rise : int_rise;
   assign fall_ev = cfg_q.ext_clk ? ext_fall : int_fall;
   assign sck_oe  = !cfg_q.ext_clk;

   bitser_shifter #(
      .DATA_W (DATA_W)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .wr_data_i (dat_wdata),
      .cfg_i     (cfg_q),
      .rise_i    (rise_ev),
      .fall_i    (fall_ev),
      .sdi_i     (sdi_i),
      .sdo_o     (sdo_o),
      .busy_o    (busy),
      .done_o    (done),
      .irq_o     (irq),
      .rx_o      (rd_data)
   );

   AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o); // R2
   AST_EXT_CLK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.ext_clk |-> sck_o); // R7
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_q)); // R10

endmodule

// File: tb/bitser_port_bench.sv
`timescale 1ns/1ps
module bitser_port_bench;

   localparam int DW = 8;
   localparam int DH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_we = 1'b0;
   logic [2:0]    ctl_wdata = '0;
   logic          dat_we = 1'b0;
   logic [DW-1:0] dat_wdata = '0;
   logic [DW-1:0] rd_data;
   logic          done, irq;
   logic          sck_i = 1'b1;
   logic          sck_o, sck_oe, sdo_o;
   logic          sdi_i = 1'b0;

   int checks = 0;
   int errors = 0;
   int neg_cnt = 0;

   bitser_port #(.DATA_W(DW), .DIV_HALF(DH), .SYNC_STAGES(2)) u_bitser_port (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .dat_we(dat_we), .dat_wdata(dat_wdata), .rd_data(rd_data), .done(done),
      .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .sdo_o(sdo_o), .sdi_i(sdi_i)
   );

   always #2.5 clk = ~clk;
   always @(negedge sck_o) neg_cnt++;

   function automatic logic bit_at(input logic [DW-1:0] b, input int i, input logic msb);
      return msb ? b[DW-1-i] : b[i];
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act %0h exp %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic write_cfg(input logic msb, input logic rxo, input logic ext);
      ctl_wdata = {ext, rxo, msb};
      ctl_we = 1'b1;
      step();
      ctl_we = 1'b0;
   endtask

   task automatic check_reset();
      chk(sck_o == 1'b1,  "R1 sck_o",  sck_o, 1);
      chk(sck_oe == 1'b1, "R1 sck_oe", sck_oe, 1);
      chk(sdo_o == 1'b1,  "R1 sdo_o",  sdo_o, 1);
      chk(done == 1'b0,   "R1 done",   done, 0);
      chk(irq == 1'b0,    "R1 irq",    irq, 0);
      chk(rd_data == '0,  "R1 rd_data", rd_data, 0);
   endtask

   // Master transfer against a bench slave that changes sdi just after each rise
   task automatic run_master(input logic [DW-1:0] tx, input logic [DW-1:0] sl,
                             input logic msb, input logic rxo, input logic intrude);
      logic [DW-1:0] cap;
      logic sdo_before;
      int cyc, irqc, n0;
      string rq;
      rq = msb ? "R3" : "R4";
      write_cfg(msb, rxo, 1'b0);
      sdo_before = sdo_o;
      n0 = neg_cnt;
      sdi_i = bit_at(sl, 0, msb);
      dat_wdata = tx;
      cyc = 0;
      irqc = 0;
      fork
         begin
            for (int i = 0; i < DW; i++) begin
               @(posedge sck_o);
               cap[i] = sdo_o;
               #1;
               if (i < DW-1) sdi_i = bit_at(sl, i+1, msb);
            end
         end
         begin
            dat_we = 1'b1;
            step();
            dat_we = 1'b0;
            chk(done == 1'b0, "R9 done cleared", done, 0);
            if (intrude) begin
               for (int k = 0; k < 10; k++) begin
                  step(); cyc++; if (irq) irqc++;
               end
               dat_wdata = 8'h3C; dat_we = 1'b1;
               ctl_wdata = 3'b100; ctl_we = 1'b1;
               step(); cyc++; if (irq) irqc++;
               dat_we = 1'b0; ctl_we = 1'b0;
            end
            while (!done && cyc < 2000) begin
               step(); cyc++; if (irq) irqc++;
            end
         end
      join
      chk(cyc == (2*DW-1)*DH, "R8 latency", cyc, (2*DW-1)*DH);
      chk(irqc == 1, "R8 irq width", irqc, 1);
      step();
      chk(irq == 1'b0, "R8 irq cleared", irq, 0);
      repeat (2*DH) step();
      chk(neg_cnt - n0 == DW, "R2 pulse count", neg_cnt - n0, DW);
      chk(sck_o == 1'b1, "R2 idle high", sck_o, 1);
      chk(rd_data == sl, {rq, " R5 rx byte"}, rd_data, sl);
      for (int i = 0; i < DW; i++) begin
         if (rxo) chk(cap[i] == sdo_before, "R6 sdo hold", cap[i], sdo_before);
         else     chk(cap[i] == bit_at(tx, i, msb), {rq, " tx bit"}, cap[i], bit_at(tx, i, msb));
      end
      if (intrude) begin
         chk(sck_oe == 1'b1, "R10 ctl write ignored", sck_oe, 1);
         chk(done == 1'b1, "R10 done", done, 1);
      end
   endtask

   // Slave transfer with the bench acting as clock master on sck_i
   task automatic run_slave(input logic [DW-1:0] tx, input logic [DW-1:0] mb,
                            input logic msb, input logic rxo);
      logic sdo_before;
      logic expb;
      write_cfg(msb, rxo, 1'b1);
      chk(sck_oe == 1'b0, "R7 oe off", sck_oe, 0);
      sdo_before = sdo_o;
      dat_wdata = tx;
      dat_we = 1'b1;
      step();
      dat_we = 1'b0;
      for (int i = 0; i < DW; i++) begin
         sck_i = 1'b0;
         sdi_i = bit_at(mb, i, msb);
         repeat (6) step();
         expb = rxo ? sdo_before : bit_at(tx, i, msb);
         chk(sdo_o == expb, rxo ? "R6 ext sdo hold" : "R7 ext tx bit", sdo_o, expb);
         if (i == DW-1) chk(done == 1'b0, "R7 not done early", done, 0);
         sck_i = 1'b1;
         repeat (6) step();
      end
      chk(done == 1'b1, "R7 done", done, 1);
      chk(rd_data == mb, "R7 rx byte", rd_data, mb);
      chk(sck_o == 1'b1, "R7 sck_o silent", sck_o, 1);
   endtask

   task automatic idle_edges();
      logic [DW-1:0] rd0;
      logic d0, s0;
      rd0 = rd_data; d0 = done; s0 = sdo_o;
      for (int i = 0; i < 3; i++) begin
         sck_i = 1'b0; sdi_i = ~sdi_i;
         repeat (6) step();
         sck_i = 1'b1;
         repeat (6) step();
      end
      chk(done == d0, "R11 done", done, d0);
      chk(rd_data == rd0, "R11 rd_data", rd_data, rd0);
      chk(sdo_o == s0, "R11 sdo", sdo_o, s0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog act 1 exp 0");
      finish_run();
   end

   initial begin : main
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      check_reset();
      run_master(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0);
      run_master(8'h4E, 8'hD1, 1'b0, 1'b0, 1'b0);
      run_master(8'hFF, 8'h96, 1'b1, 1'b1, 1'b0);
      run_master(8'h5A, 8'h0F, 1'b0, 1'b0, 1'b1);
      run_slave(8'hC3, 8'h81, 1'b1, 1'b0);
      run_slave(8'h29, 8'h6B, 1'b0, 1'b1);
      idle_edges();
      run_slave(8'h17, 8'hE4, 1'b0, 1'b0);
      finish_run();
   end

endmodule